// File: doc/BRIEF.md
# NOR flash command sequencer

This block is the device side of a word-wide parallel NOR flash, reduced to its command logic. It watches the bus strobes (chip enable, write enable and output enable), the address and the data, all already synchronized to the system clock. From the order of the bus writes it picks out the commands: the two-step unlock, word program, a shortened bypass program, chip erase, sector erase with a collection window, erase suspend and resume, and a reset command. The block holds a small internal array. Program and erase run as timed stand-ins for the embedded algorithms, and they change that array one word at a time.

While an operation runs, a read does not return array data. It returns a status word. In that word, bit 7 is the complement of the bit 7 being programmed, bit 6 flips on every read, bit 5 flags a timeout and bit 3 shows that the erase window has closed. A `busy` output gives the same information as a pin. The sector count, the words per sector, the program time, the timeout limit and the erase window are all parameters.

Top module: `nor_cmd_seq`

## Requirements
- R1: A bus write is taken when `we_n` rises while `ce_n` is low. The sequence 0x00AA at 0x555, 0x0055 at 0x2AA, 0x00A0 at 0x555, then the target address and data starts a program. `busy` is high for exactly PROG_CYCLES clock cycles after the last write. After that, the word reads back as the old content ANDed with the new data.
- R2: A wrong address or data value in any unlock or erase-setup cycle returns the block to read mode. This includes the reset value 0x00F0. Nothing is programmed and `busy` stays low.
- R3: During a program, bit 7 of a read is the complement of bit 7 of the data being written. After completion, the true data is returned.
- R4: During any program or erase, bit 6 of the read value flips on every successive read. Once the operation ends, repeated reads return the same array data.
- R5: Unlock followed by 0x0020 at 0x555 enters bypass mode. In bypass mode, 0x00A0 at any address followed by one address/data write programs a word. The pair 0x0090, 0x0000 leaves bypass mode. While `acc` is high in read mode, the block enters bypass mode without any command.
- R6: The erase-setup sequence (unlock, 0x0080 at 0x555, unlock) followed by 0x0010 at 0x555 erases the whole array to all ones. `busy` stays high for exactly 2×WORDS cycles: one preprogram pass and one erase pass, each of one word per cycle.
- R7: After erase setup, 0x0030 written to a sector address selects that sector and opens a window of ERASE_WINDOW cycles. Each further 0x0030 write selects another sector and restarts the window. Only the selected sectors become all ones.
- R8: Status bit 3 is 0 while the sector window is open. It is 1 while the erase itself runs.
- R9: During an erase, 0x00B0 at any address suspends it and `busy` drops. While suspended, reads of unselected sectors return array data, and reads of selected sectors return 0x0080. A program to an unselected sector works, and a program to a selected sector is ignored. A write of 0x0030 resumes the erase.
- R10: A program that needs any bit to go from 0 to 1 fails verify. After PROG_LIMIT cycles, status bit 5 is set. The block then stays busy until it receives a 0x00F0 write, and the target word is left unchanged.
- R11: A low level on `dev_reset_n` at a clock edge aborts any operation. `busy` is low after that edge, and reads return array data. The array keeps its contents.
- R12: `rdata` is zero whenever `ce_n` or `oe_n` is high. After `rst_n`, the array reads all ones and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset; also sets the array to all ones |
| dev_reset_n | input | 1 | Synchronous hardware reset; aborts the current operation and keeps the array |
| acc | input | 1 | Acceleration level; forces bypass mode from read mode |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; its rising edge takes the write |
| oe_n | input | 1 | Output enable, active low; its falling edge counts as a read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Array data or status word |
| busy | output | 1 | High while a program or erase is active |

## Verification
Every result is registered at the clock edge that samples the strobe edge, so the bench drives only on falling clock edges. It samples a read one falling edge after pulling `oe_n` low. `busy` rises one edge after the last write of a command. It then stays high for exactly PROG_CYCLES cycles for a program and 2×WORDS cycles for a chip erase. The bench checks it high on the last falling edge of that span and low on the next one. For `dev_reset_n` and suspend, the bench expects `busy` low on the first falling edge after the edge that takes them. The window for status bit 3 and the timeout for bit 5 are checked with margins well inside and well outside their parameter lengths.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 16,
  parameter int SECTORS      = 4,
  parameter int SECTOR_WORDS = 16,
  parameter int PROG_CYCLES  = 8,
  parameter int PROG_LIMIT   = 24,
  parameter int ERASE_WINDOW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_reset_n,
  input  logic              acc,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);
  localparam int WORDS = SECTORS * SECTOR_WORDS;
  localparam int IW    = $clog2(WORDS);
  localparam int WB    = $clog2(SECTOR_WORDS);
  localparam int SW    = IW - WB;
  localparam int CW    = $clog2(PROG_LIMIT + 1);
  localparam int WW    = $clog2(ERASE_WINDOW + 1);

  typedef enum logic [3:0] {
    S_RD, S_UL1, S_UL2, S_PGA, S_ER1, S_ER2, S_ER3,
    S_BYP, S_BYA, S_BYX, S_PROG, S_EWIN, S_ERASE, S_SUSP
  } st_t;

  st_t               state, ret_st, home;
  logic              we_q, oe_q, wr_ev, rd_ev;
  logic              in_susp, pfail, to_flag, phase, tgl;
  logic [SECTORS-1:0] sel;
  logic [CW-1:0]     cnt;
  logic [WW-1:0]     wcnt;
  logic [IW-1:0]     idx, pa, widx;
  logic [SW-1:0]     wsec, rsec;
  logic [DATA_W-1:0] pd, rv;
  logic [DATA_W-1:0] mem [WORDS];
  logic [7:0]        cmd;
  logic              at555, at2aa, prog_done, prog_to;

  assign wr_ev = ~we_q & we_n & ~ce_n;
  assign rd_ev = oe_q & ~oe_n & ~ce_n;
  assign cmd   = wdata[7:0];
  assign at555 = addr[10:0] == 11'h555;
  assign at2aa = addr[10:0] == 11'h2AA;
  assign widx  = addr[IW-1:0];
  assign wsec  = addr[IW-1:WB];
  assign rsec  = addr[IW-1:WB];
  assign home  = in_susp ? S_SUSP : S_RD;
  assign busy  = (state == S_PROG) || (state == S_EWIN) || (state == S_ERASE);
  assign prog_done = (state == S_PROG) && !to_flag && !pfail && cnt == CW'(PROG_CYCLES - 1);
  assign prog_to   = (state == S_PROG) && !to_flag && pfail && cnt == CW'(PROG_LIMIT - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      we_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      we_q <= we_n;
      oe_q <= oe_n;
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_RD;  ret_st <= S_RD;  in_susp <= 1'b0;  sel <= '0;
      cnt <= '0;  wcnt <= '0;  idx <= '0;  phase <= 1'b0;  tgl <= 1'b0;
      pfail <= 1'b0;  to_flag <= 1'b0;  pa <= '0;  pd <= '0;
    end else if (!dev_reset_n) begin
      state <= S_RD;  ret_st <= S_RD;  in_susp <= 1'b0;  sel <= '0;
      cnt <= '0;  wcnt <= '0;  idx <= '0;  phase <= 1'b0;  tgl <= 1'b0;
      pfail <= 1'b0;  to_flag <= 1'b0;
    end else begin
      if (rd_ev && busy) tgl <= ~tgl;
      case (state)
        S_RD:
          if (wr_ev) begin
            if (at555 && cmd == 8'hAA) state <= S_UL1;
          end else if (acc) state <= S_BYP;
        S_SUSP:
          if (wr_ev) begin
            if (at555 && cmd == 8'hAA) state <= S_UL1;
            else if (cmd == 8'h30) begin
              state   <= S_ERASE;
              in_susp <= 1'b0;
            end
          end
        S_UL1:
          if (wr_ev) state <= (at2aa && cmd == 8'h55) ? S_UL2 : home;
        S_UL2:
          if (wr_ev) begin
            if (at555 && cmd == 8'hA0)                   state <= S_PGA;
            else if (!in_susp && at555 && cmd == 8'h80)  state <= S_ER1;
            else if (!in_susp && at555 && cmd == 8'h20)  state <= S_BYP;
            else                                         state <= home;
          end
        S_ER1:
          if (wr_ev) state <= (at555 && cmd == 8'hAA) ? S_ER2 : S_RD;
        S_ER2:
          if (wr_ev) state <= (at2aa && cmd == 8'h55) ? S_ER3 : S_RD;
        S_ER3:
          if (wr_ev) begin
            if (at555 && cmd == 8'h10) begin
              sel   <= '1;
              idx   <= '0;
              phase <= 1'b0;
              state <= S_ERASE;
            end else if (cmd == 8'h30) begin
              sel   <= {{(SECTORS-1){1'b0}}, 1'b1} << wsec;
              wcnt  <= '0;
              state <= S_EWIN;
            end else state <= S_RD;
          end
        S_PGA, S_BYA:
          if (wr_ev) begin
            if (in_susp && sel[wsec]) state <= S_SUSP;
            else begin
              pa      <= widx;
              pd      <= wdata;
              pfail   <= |(wdata & ~mem[widx]);
              cnt     <= '0;
              to_flag <= 1'b0;
              ret_st  <= (state == S_BYA) ? S_BYP : home;
              state   <= S_PROG;
            end
          end
        S_BYP:
          if (wr_ev) begin
            if (cmd == 8'hA0)      state <= S_BYA;
            else if (cmd == 8'h90) state <= S_BYX;
          end
        S_BYX:
          if (wr_ev) state <= (cmd == 8'h00) ? S_RD : S_BYP;
        S_PROG:
          if (to_flag) begin
            if (wr_ev && cmd == 8'hF0) begin
              state   <= S_RD;
              in_susp <= 1'b0;
              sel     <= '0;
              to_flag <= 1'b0;
            end
          end else if (prog_done) state <= ret_st;
          else if (prog_to)       to_flag <= 1'b1;
          else                    cnt <= cnt + 1'b1;
        S_EWIN:
          if (wr_ev && cmd == 8'h30) begin
            sel[wsec] <= 1'b1;
            wcnt      <= '0;
          end else if (wcnt == WW'(ERASE_WINDOW - 1)) begin
            idx   <= '0;
            phase <= 1'b0;
            state <= S_ERASE;
          end else wcnt <= wcnt + 1'b1;
        S_ERASE:
          if (wr_ev && cmd == 8'hB0) begin
            state   <= S_SUSP;
            in_susp <= 1'b1;
          end else if (idx == IW'(WORDS - 1)) begin
            idx <= '0;
            if (phase) begin
              state <= S_RD;
              sel   <= '0;
            end else phase <= 1'b1;
          end else idx <= idx + 1'b1;
        default: state <= S_RD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (dev_reset_n) begin
      if (prog_done) mem[pa] <= mem[pa] & pd;
      else if (state == S_ERASE && sel[idx[IW-1:WB]]) mem[idx] <= phase ? '1 : '0;
    end
  end

  always_comb begin
    rv = '0;
    if (state == S_PROG) begin
      rv[7] = ~pd[7];
      rv[6] = tgl;
      rv[5] = to_flag;
    end else if (state == S_EWIN || state == S_ERASE) begin
      rv[6] = tgl;
      rv[3] = (state == S_ERASE);
    end else if (in_susp && sel[rsec]) rv[7] = 1'b1;
    else rv = mem[addr[IW-1:0]];
  end

  assign rdata = (ce_n | oe_n) ? '0 : rv;

  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_reset_n |=> !busy);
  a_r1_busy_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_ev));
  a_r10_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (to_flag && dev_reset_n && !(wr_ev && cmd == 8'hF0)) |=> busy);
  a_r8_no_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ERASE) |=> (state != S_EWIN));
  a_r9_susp_targets: assert property (@(posedge clk) disable iff (!rst_n)
    in_susp |-> (sel != '0));
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(PROG_LIMIT - 1));
  a_r5_acc_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD && acc && !wr_ev && dev_reset_n) |=> (state == S_BYP));
endmodule

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;
  localparam int P = 8, LIM = 24, W = 12, WORDS = 64;

  logic clk = 1'b0, rst_n = 1'b0, dev_reset_n = 1'b1, acc = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0;
  logic [15:0] wdata = '0, rdata, v;
  logic busy;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nor_cmd_seq dut_i (.clk(clk), .rst_n(rst_n), .dev_reset_n(dev_reset_n), .acc(acc),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .busy(busy));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    ce_n = 1'b0; addr = a; wdata = d; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic rd(input logic [10:0] a, output logic [15:0] d);
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk); d = rdata;
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(11'h555, 16'h00AA);
    wr(11'h2AA, 16'h0055);
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 400) begin @(negedge clk); n++; end
    if (busy) chk({tag, " idle"}, 16'(busy), 16'h0);
  endtask

  task automatic prog(input logic [10:0] a, input logic [15:0] d);
    unlock(); wr(11'h555, 16'h00A0); wr(a, d); wait_idle("prog");
  endtask

  task automatic busy_window(input string tag, input int n);
    chk({tag, " busy start"}, 16'(busy), 16'h1);
    repeat (n - 1) @(negedge clk);
    chk({tag, " busy last"}, 16'(busy), 16'h1);
    @(negedge clk);
    chk({tag, " busy end"}, 16'(busy), 16'h0);
  endtask

  task automatic t_reset();
    chk("R12 idle rdata", rdata, 16'h0000);
    chk("R12 busy after reset", 16'(busy), 16'h0);
    rd(11'd3, v); chk("R12 erased array", v, 16'hFFFF);
  endtask

  task automatic t_prog();
    unlock(); wr(11'h555, 16'h00A0); wr(11'd5, 16'h1234);
    busy_window("R1 program", P);
    rd(11'd5, v); chk("R1 readback", v, 16'h1234);
  endtask

  task automatic t_poll();
    logic [15:0] s1, s2;
    unlock(); wr(11'h555, 16'h00A0); wr(11'd6, 16'h00C3);
    rd(11'd6, s1); rd(11'd6, s2);
    chk("R3 bit7 complement", 16'(s1[7]), 16'h0);
    chk("R4 bit6 flips", 16'(s1[6] ^ s2[6]), 16'h1);
    wait_idle("R3");
    rd(11'd6, s1); rd(11'd6, s2);
    chk("R3 true data", s1, 16'h00C3);
    chk("R4 stable after end", s2, 16'h00C3);
  endtask

  task automatic t_badunlock();
    wr(11'h555, 16'h00AA); wr(11'h2AB, 16'h0055); wr(11'h555, 16'h00A0); wr(11'd7, 16'h0000);
    chk("R2 bad address no busy", 16'(busy), 16'h0);
    rd(11'd7, v); chk("R2 bad address no write", v, 16'hFFFF);
    unlock(); wr(11'h555, 16'h00F0); wr(11'h555, 16'h00A0); wr(11'd7, 16'h0000);
    chk("R2 reset cmd no busy", 16'(busy), 16'h0);
    rd(11'd7, v); chk("R2 reset cmd no write", v, 16'hFFFF);
  endtask

  task automatic t_bypass();
    unlock(); wr(11'h555, 16'h0020);
    wr(11'h000, 16'h00A0); wr(11'd8, 16'h5A5A); wait_idle("R5");
    wr(11'h123, 16'h00A0); wr(11'd9, 16'h0F0F); wait_idle("R5");
    rd(11'd8, v); chk("R5 bypass word 8", v, 16'h5A5A);
    rd(11'd9, v); chk("R5 bypass word 9", v, 16'h0F0F);
    wr(11'h000, 16'h0090); wr(11'h000, 16'h0000);
    wr(11'h000, 16'h00A0); wr(11'd10, 16'h0000);
    chk("R5 exit no busy", 16'(busy), 16'h0);
    rd(11'd10, v); chk("R5 exited bypass", v, 16'hFFFF);
    acc = 1'b1; repeat (2) @(negedge clk);
    wr(11'h000, 16'h00A0); wr(11'd11, 16'h1111); wait_idle("R5");
    rd(11'd11, v); chk("R5 acc bypass program", v, 16'h1111);
    acc = 1'b0;
    wr(11'h000, 16'h0090); wr(11'h000, 16'h0000);
  endtask

  task automatic t_timeout();
    unlock(); wr(11'h555, 16'h00A0); wr(11'd5, 16'hFFFF);
    repeat (LIM + 6) @(negedge clk);
    chk("R10 still busy", 16'(busy), 16'h1);
    rd(11'd5, v);
    chk("R10 bit5 set", 16'(v[5]), 16'h1);
    chk("R10 bit7 complement", 16'(v[7]), 16'h0);
    wr(11'h000, 16'h00F0);
    chk("R10 cleared by F0", 16'(busy), 16'h0);
    rd(11'd5, v); chk("R10 word unchanged", v, 16'h1234);
  endtask

  task automatic erase_setup();
    unlock(); wr(11'h555, 16'h0080); unlock();
  endtask

  task automatic t_sector();
    prog(11'd20, 16'h2222);
    prog(11'd40, 16'h4444);
    erase_setup(); wr(11'd0, 16'h0030);
    rd(11'd0, v); chk("R8 bit3 in window", 16'(v[3]), 16'h0);
    wr(11'd40, 16'h0030);
    repeat (W + 2) @(negedge clk);
    rd(11'd0, v); chk("R8 bit3 running", 16'(v[3]), 16'h1);
    wr(11'h000, 16'h00B0);
    chk("R9 suspend drops busy", 16'(busy), 16'h0);
    rd(11'd20, v); chk("R9 unselected read", v, 16'h2222);
    rd(11'd5, v);  chk("R9 selected read", v, 16'h0080);
    prog(11'd21, 16'h2121);
    rd(11'd21, v); chk("R9 program unselected", v, 16'h2121);
    chk("R9 back in suspend", 16'(busy), 16'h0);
    unlock(); wr(11'h555, 16'h00A0); wr(11'd41, 16'h0000);
    chk("R9 selected program ignored", 16'(busy), 16'h0);
    rd(11'd5, v);  chk("R9 still suspended", v, 16'h0080);
    wr(11'h000, 16'h0030);
    chk("R9 resume busy", 16'(busy), 16'h1);
    wait_idle("R9");
    rd(11'd5, v);  chk("R7 sector0 erased", v, 16'hFFFF);
    rd(11'd40, v); chk("R7 sector2 erased", v, 16'hFFFF);
    rd(11'd41, v); chk("R7 R9 ignored word erased", v, 16'hFFFF);
    rd(11'd20, v); chk("R7 sector1 kept", v, 16'h2222);
    rd(11'd21, v); chk("R7 suspend program kept", v, 16'h2121);
  endtask

  task automatic t_abort();
    erase_setup(); wr(11'h555, 16'h0010);
    repeat (10) @(negedge clk);
    dev_reset_n = 1'b0;
    @(negedge clk);
    chk("R11 busy dropped", 16'(busy), 16'h0);
    dev_reset_n = 1'b1;
    rd(11'd0, v);  chk("R11 array read preprogrammed", v, 16'h0000);
    rd(11'd20, v); chk("R11 untouched word", v, 16'h2222);
  endtask

  task automatic t_chip();
    erase_setup(); wr(11'h555, 16'h0010);
    busy_window("R6 chip erase", 2 * WORDS);
    rd(11'd20, v); chk("R6 word 20 erased", v, 16'hFFFF);
    rd(11'd63, v); chk("R6 last word erased", v, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prog();
    t_poll();
    t_badunlock();
    t_bypass();
    t_timeout();
    t_sector();
    t_abort();
    t_chip();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule